// File: doc/BRIEF.md
# Page-Buffered Write Controller with Load Timeout

This controller sits in front of an on-chip nonvolatile memory model. A host issues single-cycle write strobes, each with an 11-bit address and a data byte. The address splits into a page number (upper 5 bits) and a byte offset (lower 6 bits). The first strobe opens a load and fixes the page. Further strobes to the same page land in a 64-entry page buffer. Every accepted byte restarts an inactivity timer. When the host stays quiet for `LOAD_TMO` cycles, the load window closes and the controller becomes busy.

While busy, the controller first sweeps the buffer. It copies only the slots that were written into the memory array and leaves every other cell of the page as it was. It then waits out a write-cycle timer of `WRITE_CYC` cycles before it returns to idle. During the busy period, write strobes are ignored, and reads return a status byte in place of array data. A page of a single byte is simply a load with one strobe.

The states are named as follows:
- **ST_IDLE**: no load is open.
- **ST_LOAD**: the window is open and bytes are collected.
- **ST_COMMIT**: the buffer is swept into the array, one slot per cycle.
- **ST_PROG**: the write-cycle timer is running.

The transitions are named as follows:
- **open**: IDLE to LOAD, on the first strobe.
- **expire**: LOAD to COMMIT, on timeout with no strobe accepted in that cycle.
- **swept**: COMMIT to PROG, after the last slot.
- **done**: PROG to IDLE, when the write-cycle count is reached.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `pl_expired` is 1, `last_addr` is 0 and `last_data` is 0. Reset does not alter the contents of the memory array.
- R2: A strobe in ST_IDLE opens a load and latches page bits [10:6]. At the following clock edge, `last_addr` and `last_data` show the accepted address and byte.
- R3: During a load, a strobe whose bits [10:6] differ from the latched page is ignored. It leaves `last_addr` and `last_data` unchanged, is never written to the array, and does not restart the load timer.
- R4: `pl_expired` is 0 while a load is open. It rises exactly `LOAD_TMO` cycles after the clock edge that accepted the last byte.
- R5: `busy` rises on the same edge as `pl_expired`. It stays high for exactly 64 + `WRITE_CYC` cycles (a 64-cycle buffer sweep, then the write-cycle timer). `pl_expired` stays high throughout.
- R6: A commit updates only the offsets written during the load; the other cells of the page keep their values. When an offset is written more than once in one load, the last byte wins.
- R7: Write strobes that arrive while `busy` is high have no effect on `last_addr`, `last_data` or the array.
- R8: When not busy, a read strobe returns the array byte at `rd_addr` on `rd_data` one cycle later.
- R9: When busy, a read strobe returns a status byte one cycle later:
  - bit 7 is the complement of bit 7 of `last_data`;
  - bit 6 is a toggle that reads 0 on the first read of a busy period and alternates on each later read;
  - bit 5 is 1;
  - bits 4..0 are 0.
- R10: A reset during an open load discards the buffered bytes and their valid marks. A later load of the same page does not commit them.
- R11: A load of exactly one byte commits that byte and follows the same timing as R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 11 | Write address, page in [10:6], offset in [5:0] |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Registered read result: array byte, or status byte while busy |
| busy | output | 1 | Sweep or write-cycle timer in progress |
| pl_expired | output | 1 | 0 while the load window is open, 1 otherwise |
| last_addr | output | 11 | Address of the last accepted byte |
| last_data | output | 8 | Last accepted byte |

## Verification
The bench builds the controller with `LOAD_TMO` = 8 and `WRITE_CYC` = 20, and leaves the 64-byte page geometry at its default. These short timers let a run include full 64-byte pages, gaps between strobes up to one cycle short of the timeout, off-page strobes placed inside those gaps, and the exact closing edges of both the load window and the busy period. The small write-cycle time also leaves room for status reads and ignored writes within a busy period.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_PROG   = 2'd3
    } plc_state_e;

endpackage

// File: rtl/plc_cycle_counter.sv
// Up-counter with synchronous clear; flags when the count equals LIMIT.
module plc_cycle_counter #(
    parameter int unsigned LIMIT = 1,
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_limit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && !at_limit) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == CW'(LIMIT));

endmodule

// File: rtl/plc_page_buffer.sv
// Page staging buffer with one valid mark per slot.
module plc_page_buffer #(
    parameter int unsigned OFF_W  = 6,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SLOTS = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              first,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  mark_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                slot_q[s] <= '0;
            end
            mark_q <= '0;
        end else if (we) begin
            // First byte of a load clears all marks except its own slot.
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_off == OFF_W'(s)) begin
                    slot_q[s] <= wr_data;
                    mark_q[s] <= 1'b1;
                end else if (first) begin
                    mark_q[s] <= 1'b0;
                end
            end
        end
    end

    assign rd_data  = slot_q[rd_off];
    assign rd_valid = mark_q[rd_off];

endmodule

// File: rtl/plc_mem_array.sv
// Register-array memory model: one write port, one combinational read port, no reset.
module plc_mem_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned OFF_W     = 6,
    parameter int unsigned LOAD_TMO  = 400,
    parameter int unsigned WRITE_CYC = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [10:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [10:0]       rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              pl_expired,
    output logic [10:0]       last_addr,
    output logic [7:0]        last_data
);

    localparam int unsigned PAGE_W     = ADDR_W - OFF_W;
    localparam int unsigned PAGE_BYTES = 1 << OFF_W;
    localparam int unsigned TMO_LIMIT  = LOAD_TMO - 1;
    localparam int unsigned PROG_LIMIT = (WRITE_CYC > 0) ? WRITE_CYC - 1 : 0;
    localparam int unsigned SWEEP_LIM  = PAGE_BYTES - 1;

    // ---------------- state register ----------------
    plc_state_e state_q, state_d;

    // ---------------- internal nets -----------------
    logic              accept;
    logic              first_byte;
    logic [PAGE_W-1:0] wr_page;
    logic [PAGE_W-1:0] page_q;
    logic              tmr_clr, tmr_inc, tmr_hit;
    logic              prg_clr, prg_inc, prg_hit;
    logic              swp_clr, swp_inc, swp_hit;
    logic [OFF_W-1:0]  swp_idx;
    logic [DATA_W-1:0] buf_data;
    logic              buf_valid;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] status_byte;
    logic              tog_q;
    logic [DATA_W-1:0] rd_data_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic [DATA_W-1:0] last_data_q;
    logic              busy_o, expired_o;

    assign wr_page = wr_addr[ADDR_W-1:OFF_W];

    // Accept a byte while idle, or while loading if it carries the latched page.
    assign first_byte = wr_en && (state_q == ST_IDLE);
    assign accept     = first_byte ||
                        (wr_en && (state_q == ST_LOAD) && (wr_page == page_q));

    // ---------------- state register process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)              state_d = ST_LOAD;   // open
            ST_LOAD:   if (!accept && tmr_hit)  state_d = ST_COMMIT; // expire
            ST_COMMIT: if (swp_hit)             state_d = ST_PROG;   // swept
            ST_PROG:   if (prg_hit)             state_d = ST_IDLE;   // done
            default:                            state_d = ST_IDLE;
        endcase
    end

    // ---------------- output / control decode process ----------------
    always_comb begin
        busy_o    = 1'b0;
        expired_o = 1'b1;
        tmr_clr   = 1'b1;
        tmr_inc   = 1'b0;
        swp_clr   = 1'b1;
        swp_inc   = 1'b0;
        prg_clr   = 1'b1;
        prg_inc   = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LOAD: begin
                expired_o = 1'b0;
                tmr_clr   = accept;
                tmr_inc   = 1'b1;
            end
            ST_COMMIT: begin
                busy_o  = 1'b1;
                swp_clr = 1'b0;
                swp_inc = 1'b1;
                mem_we  = buf_valid;
            end
            ST_PROG: begin
                busy_o  = 1'b1;
                prg_clr = 1'b0;
                prg_inc = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // ---------------- timers ----------------
    plc_cycle_counter #(.LIMIT(TMO_LIMIT)) load_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .inc      (tmr_inc),
        .count    (),
        .at_limit (tmr_hit)
    );

    plc_cycle_counter #(.LIMIT(SWEEP_LIM)) sweep_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (swp_clr),
        .inc      (swp_inc),
        .count    (swp_idx),
        .at_limit (swp_hit)
    );

    plc_cycle_counter #(.LIMIT(PROG_LIMIT)) prog_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (prg_clr),
        .inc      (prg_inc),
        .count    (),
        .at_limit (prg_hit)
    );

    // ---------------- page buffer and array ----------------
    plc_page_buffer #(.OFF_W(OFF_W), .DATA_W(DATA_W)) pbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (accept),
        .first    (first_byte),
        .wr_off   (wr_addr[OFF_W-1:0]),
        .wr_data  (wr_data),
        .rd_off   (swp_idx),
        .rd_data  (buf_data),
        .rd_valid (buf_valid)
    );

    plc_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({page_q, swp_idx}),
        .wdata (buf_data),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q      <= '0;
            last_addr_q <= '0;
            last_data_q <= '0;
        end else if (accept) begin
            if (first_byte) begin
                page_q <= wr_page;
            end
            last_addr_q <= wr_addr;
            last_data_q <= wr_data;
        end
    end

    // Status byte: inverted polling bit, toggle bit, window-closed bit.
    always_comb begin
        status_byte            = '0;
        status_byte[DATA_W-1]  = ~last_data_q[DATA_W-1];
        status_byte[DATA_W-2]  = tog_q;
        status_byte[DATA_W-3]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q     <= 1'b0;
            rd_data_q <= '0;
        end else begin
            if (state_q == ST_LOAD) begin
                tog_q <= 1'b0;
            end else if (rd_en && busy_o) begin
                tog_q <= ~tog_q;
            end
            if (rd_en) begin
                rd_data_q <= busy_o ? status_byte : mem_rdata;
            end
        end
    end

    assign rd_data    = rd_data_q;
    assign busy       = busy_o;
    assign pl_expired = expired_o;
    assign last_addr  = last_addr_q;
    assign last_data  = last_data_q;

endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned OFF_W  = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [7:0]  rd_data,
    input logic        busy,
    input logic        pl_expired,
    input logic [10:0] last_addr,
    input logic [7:0]  last_data
);

    // R7: nothing is accepted during a busy cycle
    p_busy_ignores_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    // R3: within one open load, the page bits never change
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pl_expired && $past(!pl_expired)) |->
            (last_addr[ADDR_W-1:OFF_W] == $past(last_addr[ADDR_W-1:OFF_W])));

    // R5: window stays closed throughout a busy period
    p_busy_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pl_expired);

    // R5: busy only begins at the end of an open load
    p_busy_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!pl_expired));

    // R9: a busy read returns a status byte with bit 5 set and low bits clear
    p_status_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(busy)) |-> (rd_data[5] && (rd_data[4:0] == 5'd0)));

endmodule

bind page_load_ctrl plc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .busy       (busy),
    .pl_expired (pl_expired),
    .last_addr  (last_addr),
    .last_data  (last_data)
);

// File: tb/page_load_ctrl_tb_top.sv
module page_load_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_LOAD     = 8;
    localparam int T_PROG     = 20;
    localparam int SLOTS      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, pl_expired;
    logic [10:0] last_addr;
    logic [7:0]  last_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] model [2048];
    bit         known [2048];
    logic [7:0] bdat  [SLOTS];
    bit         bval  [SLOTS];
    int         cur_page;
    logic [10:0] exp_la;
    logic [7:0]  exp_ld;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_load_ctrl #(.LOAD_TMO(T_LOAD), .WRITE_CYC(T_PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .pl_expired(pl_expired), .last_addr(last_addr), .last_data(last_data)
    );

    function automatic logic [7:0] status_of(input logic [7:0] ld, input bit tog);
        return {~ld[7], tog, 1'b1, 5'b00000};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        exp_la = '0; exp_ld = '0;
    endtask

    task automatic clear_buf(input int pg);
        cur_page = pg;
        for (int s = 0; s < SLOTS; s++) bval[s] = 1'b0;
    endtask

    // Accepted byte of the current load; checks R2 and the open window (R4).
    task automatic put(input int off, input logic [7:0] d);
        logic [10:0] a;
        a = {cur_page[4:0], off[5:0]};
        wr(a, d);
        bval[off] = 1'b1; bdat[off] = d;
        exp_la = a; exp_ld = d;
        chk(last_addr == exp_la, "R2 last_addr", last_addr, exp_la);
        chk(last_data == exp_ld, "R2 last_data", last_data, exp_ld);
        chk(pl_expired == 1'b0, "R4 window open", pl_expired, 0);
    endtask

    // Close-out of a load: timing of R4/R5, optional busy probes (R7, R9), readback (R6, R8).
    task automatic finish_page(input bit probe);
        logic [7:0] got;
        int remain;
        logic [10:0] victim;
        tick(T_LOAD - 1);
        chk(pl_expired == 1'b0, "R4 still open one cycle before timeout", pl_expired, 0);
        chk(busy == 1'b0, "R5 not busy before timeout", busy, 0);
        tick(1);
        chk(pl_expired == 1'b1, "R4 expired at timeout", pl_expired, 1);
        chk(busy == 1'b1, "R5 busy at timeout", busy, 1);
        for (int s = 0; s < SLOTS; s++) begin
            if (bval[s]) begin
                model[{cur_page[4:0], s[5:0]}] = bdat[s];
                known[{cur_page[4:0], s[5:0]}] = 1'b1;
            end
        end
        remain = 63 + T_PROG;
        if (probe) begin
            rd(exp_la, got);
            chk(got == status_of(exp_ld, 1'b0), "R9 first status read", got, status_of(exp_ld, 1'b0));
            rd(exp_la, got);
            chk(got == status_of(exp_ld, 1'b1), "R9 second status read", got, status_of(exp_ld, 1'b1));
            victim = exp_la;
            wr(victim, ~model[victim]);
            chk(last_addr == exp_la && last_data == exp_ld, "R7 busy write ignored",
                {last_addr, last_data}, {exp_la, exp_ld});
            remain -= 3;
        end
        tick(remain);
        chk(busy == 1'b1, "R5 busy on last cycle", busy, 1);
        tick(1);
        chk(busy == 1'b0, "R5 busy ends", busy, 0);
        chk(pl_expired == 1'b1, "R4 closed when idle", pl_expired, 1);
        for (int s = 0; s < SLOTS; s++) begin
            logic [10:0] a;
            a = {cur_page[4:0], s[5:0]};
            if (known[a]) begin
                rd(a, got);
                chk(got == model[a], "R6 R8 array readback", got, model[a]);
            end
        end
    endtask

    task automatic rand_page(input int pg, input int cnt, input bit use_off);
        int g;
        clear_buf(pg);
        for (int i = 0; i < cnt; i++) begin
            put($urandom % SLOTS, 8'($urandom));
            if (i < cnt - 1) begin
                g = $urandom % (T_LOAD - 1);
                if (use_off && g >= 1 && ($urandom % 3) == 0) begin
                    int opg;
                    opg = (pg + 1 + ($urandom % 31)) % 32;
                    wr({opg[4:0], 6'($urandom)}, 8'($urandom));
                    chk(last_addr == exp_la && last_data == exp_ld, "R3 off-page ignored",
                        last_addr, exp_la);
                    g--;
                end
                tick(g);
            end
        end
        finish_page(1'b0);
    endtask

    initial begin
        logic [7:0] got;
        for (int a = 0; a < 2048; a++) known[a] = 1'b0;
        void'($urandom(32'd4242));
        tick(1);
        do_reset();
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(pl_expired == 1'b1, "R1 flag after reset", pl_expired, 1);
        chk(last_addr == 11'd0 && last_data == 8'd0, "R1 last regs after reset",
            {last_addr, last_data}, 0);

        // R11 single byte page
        clear_buf(3);
        put(10, 8'h5A);
        finish_page(1'b1);

        // R6 repeated offset, neighbour kept, plus R3 timer not restarted by off-page strobe
        clear_buf(3);
        put(11, 8'hA1);
        put(11, 8'hB2);
        put(12, 8'hC3);
        wr({5'd9, 6'd12}, 8'hEE);
        chk(last_addr == exp_la, "R3 off-page keeps last_addr", last_addr, exp_la);
        tick(T_LOAD - 2);
        chk(pl_expired == 1'b0, "R3 window open before timeout", pl_expired, 0);
        tick(1);
        chk(pl_expired == 1'b1, "R3 off-page did not restart timer", pl_expired, 1);
        for (int s = 0; s < SLOTS; s++)
            if (bval[s]) begin model[{5'd3, s[5:0]}] = bdat[s]; known[{5'd3, s[5:0]}] = 1'b1; end
        tick(63 + T_PROG + 1);
        chk(busy == 1'b0, "R5 idle after commit", busy, 0);
        rd({5'd3, 6'd10}, got); chk(got == 8'h5A, "R6 untouched neighbour", got, 8'h5A);
        rd({5'd3, 6'd11}, got); chk(got == 8'hB2, "R6 last write wins", got, 8'hB2);
        rd({5'd3, 6'd12}, got); chk(got == 8'hC3, "R6 new byte", got, 8'hC3);
        known[{5'd9, 6'd12}] = 1'b0;

        // Full 64-byte sequential page
        clear_buf(17);
        for (int s = 0; s < SLOTS; s++) put(s, 8'(s * 3 + 1));
        finish_page(1'b1);

        // Random pages
        for (int p = 0; p < 6; p++) begin
            rand_page($urandom % 32, 1 + ($urandom % SLOTS), 1'b1);
        end

        // R10 reset mid-load, R1 array retained
        clear_buf(3);
        put(10, 8'h99);
        do_reset();
        chk(busy == 1'b0 && pl_expired == 1'b1, "R1 flags after mid-load reset",
            {busy, pl_expired}, 1);
        rd({5'd3, 6'd10}, got);
        chk(got == 8'h5A, "R10 R1 array kept across reset", got, 8'h5A);
        clear_buf(3);
        put(20, 8'h22);
        finish_page(1'b0);
        rd({5'd3, 6'd10}, got);
        chk(got == 8'h5A, "R10 discarded byte not committed", got, 8'h5A);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule